// File: doc/BRIEF.md
# Fully Associative Translation Cache with Least-Recently-Used Replacement

This block keeps recent virtual-page-number to physical-page-number translations so that most memory accesses skip the page table walk. A lookup presents a virtual page number and an access kind. In the same cycle the block returns hit or miss. On a hit it also returns the physical page number, the stored permission bits and a protection-fault flag when the access kind is not allowed.

On a miss the walker produces the translation and writes it through the fill port. It goes into an empty slot when one exists. Otherwise it replaces the entry that has gone longest without being used. A fill for a page that is already cached rewrites that entry, so no duplicate is created. A flush input empties the whole cache in one cycle, for example when the page table base changes.

Each entry is one translation, and any translation can sit in any entry. The entry count and both page-number widths are parameters. Each entry carries four permission bits, and the three access rights among them are checked on every hit.

Top module: `tlb_fa`

## Requirements
- R1: With `lk_valid`=1 and `lk_vpn` equal to a cached page, `lk_hit`=1 and `lk_ppn`/`lk_perm` give that entry's stored values in the same cycle. On a miss, or with `lk_valid`=0, `lk_hit`, `lk_ppn`, `lk_perm` and `lk_fault` are all 0.
- R2: A fill whose page number is already cached overwrites that entry's physical page and permissions in place. No second copy is made, so the capacity stays the full entry count.
- R3: Permission field `perm[0]`=read, `perm[1]`=write, `perm[2]`=execute, `perm[3]`=dirty. Access code 0=read, 1=write, 2=execute, 3=reserved. `lk_fault`=1 exactly when the lookup hits and the matching right bit is 0; the reserved code always faults on a hit.
- R4: While any entry is empty, a fill of a new page never evicts a cached translation.
- R5: When all entries are valid, a fill of a new page replaces the entry whose last hit or fill is oldest.
- R6: A hit (faulting or not) and a fill each make their entry the most recently used. A miss, and a lookup presented with `lk_valid`=0, change no replacement order.
- R7: `flush`=1 empties every entry at the next clock edge. A fill presented in the same cycle as a flush is dropped.
- R8: A fill applied at one clock edge is visible to lookups in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind (read/write/execute/reserved) |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | PPN_W | Physical page number on hit |
| lk_perm | output | 4 | Stored permission bits on hit |
| lk_fault | output | 1 | Hit whose access right is missing |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_perm | input | 4 | Permission bits of the fill |

## Verification
Lookup results are combinational, so they are due in the same cycle the request is presented. The bench drives each request on a falling edge and samples 1 ns later, before the next rising edge. Fills, flushes and the replacement-order update from a hit all take effect at the next rising edge. The next request, driven on the following falling edge, is therefore the first to see them. A reference model updated in that same order predicts every hit, page number, permission and fault. Because the model also predicts which page an eviction removes, later lookups check the replacement choice.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } tlb_acc_e;

   localparam int PERM_W  = 4;
   localparam int PB_READ = 0;
   localparam int PB_WRIT = 1;
   localparam int PB_EXEC = 2;
   localparam int PB_DIRT = 3;

   function automatic logic perm_allows(input logic [PERM_W-1:0] p, input tlb_acc_e a);
      case (a)
         ACC_READ:  return p[PB_READ];
         ACC_WRITE: return p[PB_WRIT];
         ACC_EXEC:  return p[PB_EXEC];
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N  = 64,
   parameter int KW = 20
) (
   input  logic [N-1:0][KW-1:0] tags,
   input  logic [N-1:0]         vld,
   input  logic [KW-1:0]        key,
   output logic [N-1:0]         match
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == key);
   end
endmodule

// File: rtl/tlb_lowest.sv
module tlb_lowest #(
   parameter int N  = 64,
   parameter int IW = 6
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/tlb_lru_ages.sv
module tlb_lru_ages #(
   parameter int N  = 64,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim_idx
);
   logic [N-1:0][IW-1:0] ages;
   logic [N-1:0]         oldest;
   logic                 oldest_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) ages[i] <= IW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)               ages[i] <= '0;
            else if (ages[i] < ages[touch_idx])    ages[i] <= ages[i] + IW'(1);
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_old
      assign oldest[g] = (ages[g] == IW'(N-1));
   end

   tlb_lowest #(.N(N), .IW(IW)) u_pick_old (
      .vec(oldest), .any(oldest_any), .idx(victim_idx)
   );

   // R5: the ages stay a permutation, so exactly one entry is the oldest
   a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      oldest_any && $countones(oldest) == 1);

   // R6: a touched entry becomes the youngest
   a_r6_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> ages[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_fa_pkg::*;
#(
   parameter int N_ENTRIES = 64,
   parameter int VPN_W     = 20,
   parameter int PPN_W     = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [1:0]        lk_acc,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   output logic              lk_fault,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm
);
   localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

   if (N_ENTRIES < 2) begin : g_bad_entries
      $error("tlb_fa: N_ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlb_fa: page number widths must be positive");
   end

   logic [N_ENTRIES-1:0]             valid_q;
   logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_q;
   logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   logic [N_ENTRIES-1:0][PERM_W-1:0] perm_q;

   logic [N_ENTRIES-1:0] lk_match, fl_match;
   logic                 lk_any, fl_any, free_any;
   logic [IDX_W-1:0]     hit_idx, fl_idx_hit, free_idx, victim_idx, fill_idx, touch_idx;
   logic                 do_fill, touch;

   tlb_cam #(.N(N_ENTRIES), .KW(VPN_W)) u_cam_lk (
      .tags(vpn_q), .vld(valid_q), .key(lk_vpn), .match(lk_match)
   );
   tlb_cam #(.N(N_ENTRIES), .KW(VPN_W)) u_cam_fl (
      .tags(vpn_q), .vld(valid_q), .key(fill_vpn), .match(fl_match)
   );

   tlb_lowest #(.N(N_ENTRIES), .IW(IDX_W)) u_pick_hit (
      .vec(lk_match), .any(lk_any), .idx(hit_idx)
   );
   tlb_lowest #(.N(N_ENTRIES), .IW(IDX_W)) u_pick_same (
      .vec(fl_match), .any(fl_any), .idx(fl_idx_hit)
   );
   tlb_lowest #(.N(N_ENTRIES), .IW(IDX_W)) u_pick_free (
      .vec(~valid_q), .any(free_any), .idx(free_idx)
   );

   tlb_lru_ages #(.N(N_ENTRIES), .IW(IDX_W)) u_ages (
      .clk(clk), .rst_n(rst_n), .touch(touch),
      .touch_idx(touch_idx), .victim_idx(victim_idx)
   );

   // lookup side
   assign lk_hit   = lk_valid && lk_any;
   assign lk_ppn   = lk_hit ? ppn_q[hit_idx]  : '0;
   assign lk_perm  = lk_hit ? perm_q[hit_idx] : '0;
   assign lk_fault = lk_hit && !perm_allows(perm_q[hit_idx], tlb_acc_e'(lk_acc));

   // fill placement: same page, then first empty slot, then oldest entry
   assign do_fill  = fill_valid && !flush;
   always_comb begin
      if (fl_any)        fill_idx = fl_idx_hit;
      else if (free_any) fill_idx = free_idx;
      else               fill_idx = victim_idx;
   end

   // a fill owns the replacement update when both happen in one cycle
   assign touch     = do_fill || lk_hit;
   assign touch_idx = do_fill ? fill_idx : hit_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q <= '0;
      else if (flush)   valid_q <= '0;
      else if (do_fill) valid_q[fill_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         vpn_q[fill_idx]  <= fill_vpn;
         ppn_q[fill_idx]  <= fill_ppn;
         perm_q[fill_idx] <= fill_perm;
      end
   end

   // R2: the fill placement never produces two entries for one page
   a_r2_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R7: a flush leaves no valid entry behind
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_q == '0);

   // R8: a fill is resident in its slot at the next cycle
   a_r8_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
      do_fill |=> valid_q[$past(fill_idx)] && vpn_q[$past(fill_idx)] == $past(fill_vpn));

   // R4: an empty slot is taken before any valid entry is replaced
   a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (do_fill && !fl_any && free_any) |-> !valid_q[fill_idx]);
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
   localparam int N  = 64;
   localparam int VW = 20;
   localparam int PW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [1:0]    lk_acc = '0;
   logic          lk_hit;
   logic [PW-1:0] lk_ppn;
   logic [3:0]    lk_perm;
   logic          lk_fault;
   logic          fill_valid = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [PW-1:0] fill_ppn = '0;
   logic [3:0]    fill_perm = '0;

   always #2 clk = ~clk;

   tlb_fa #(.N_ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_fault(lk_fault),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm)
   );

   typedef struct {
      logic          hit;
      logic [PW-1:0] ppn;
      logic [3:0]    perm;
      logic          fault;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;

   // reference model: per-slot contents and a last-use stamp
   bit            m_val[N];
   logic [VW-1:0] m_vpn[N];
   logic [PW-1:0] m_ppn[N];
   logic [3:0]    m_perm[N];
   int            m_stamp[N];
   int            now = 0;
   logic [VW-1:0] seen[$];

   function automatic int m_find(input logic [VW-1:0] v);
      for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
      return -1;
   endfunction

   function automatic logic right_ok(input logic [3:0] p, input logic [1:0] a);
      case (a)
         2'd0: return p[0];
         2'd1: return p[1];
         2'd2: return p[2];
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_lookup(input logic [VW-1:0] v, input logic [1:0] a, input string req);
      exp_t e;
      int   k;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
      lk_valid = 1'b1; lk_vpn = v; lk_acc = a;
      k = m_find(v);
      e.req = req;
      if (k >= 0) begin
         e.hit = 1'b1; e.ppn = m_ppn[k]; e.perm = m_perm[k];
         e.fault = !right_ok(m_perm[k], a);
         now++; m_stamp[k] = now;
      end else begin
         e.hit = 1'b0; e.ppn = '0; e.perm = '0; e.fault = 1'b0;
      end
      exp_q.push_back(e);
   endtask

   task automatic do_fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                          input logic [3:0] pm, input bit with_flush);
      int k;
      @(negedge clk);
      lk_valid = 1'b0;
      fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm; flush = with_flush;
      if (with_flush) begin
         for (int i = 0; i < N; i++) m_val[i] = 1'b0;
      end else begin
         k = m_find(v);
         if (k < 0) for (int i = N-1; i >= 0; i--) if (!m_val[i]) k = i;
         if (k < 0) begin
            k = 0;
            for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[k]) k = i;
         end
         m_val[k] = 1'b1; m_vpn[k] = v; m_ppn[k] = p; m_perm[k] = pm;
         now++; m_stamp[k] = now;
         seen.push_back(v);
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b1;
      for (int i = 0; i < N; i++) m_val[i] = 1'b0;
   endtask

   task automatic do_ghost(input logic [VW-1:0] v);
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
      lk_valid = 1'b0; lk_vpn = v; lk_acc = 2'd0;
   endtask

   task automatic do_idle();
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic sweep(input string req);
      int n;
      n = seen.size();
      for (int i = 0; i < n; i++) do_lookup(seen[i], 2'd0, req);
   endtask

   function automatic int oldest_slot();
      int k;
      k = 0;
      for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[k]) k = i;
      return k;
   endfunction

   // monitor: compare each lookup 1 ns after it is driven
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (lk_valid && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (lk_hit !== e.hit || lk_ppn !== e.ppn || lk_perm !== e.perm || lk_fault !== e.fault) begin
               n_fail++;
               $display("FAIL %s vpn=%h: got hit=%b ppn=%h perm=%h fault=%b exp hit=%b ppn=%h perm=%h fault=%b",
                        e.req, lk_vpn, lk_hit, lk_ppn, lk_perm, lk_fault,
                        e.hit, e.ppn, e.perm, e.fault);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int k;
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_stamp[i] = -1000 + i; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      n_tests++;
      if (lk_hit !== 1'b0 || lk_ppn !== '0 || lk_perm !== '0 || lk_fault !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: got hit=%b ppn=%h exp hit=0 ppn=0", lk_hit, lk_ppn);
      end
      do_lookup(20'h00042, 2'd0, "R1 empty miss");

      // R8: fills visible the next cycle; R1 data returned on hit
      do_fill(20'h00100, 20'hABCDE, 4'b0111, 0);
      do_lookup(20'h00100, 2'd0, "R8 next-cycle hit");
      do_fill(20'h00101, 20'h12345, 4'b0011, 0);
      do_fill(20'h00102, 20'h0F00D, 4'b0101, 0);
      do_fill(20'h00103, 20'h54321, 4'b1001, 0);
      do_lookup(20'h00101, 2'd0, "R1 hit data");
      do_lookup(20'h00102, 2'd0, "R1 hit data");
      do_lookup(20'h00999, 2'd1, "R1 miss zero");

      // R3: permission checks for every access code
      for (int a = 0; a < 4; a++) begin
         do_lookup(20'h00100, 2'(a), "R3 perm rwx");
         do_lookup(20'h00101, 2'(a), "R3 perm rw");
         do_lookup(20'h00102, 2'(a), "R3 perm rx");
         do_lookup(20'h00103, 2'(a), "R3 perm r+dirty");
      end

      // R2: refill of a cached page rewrites it in place
      do_fill(20'h00101, 20'h77777, 4'b1110, 0);
      do_lookup(20'h00101, 2'd0, "R2 in-place update");
      do_lookup(20'h00101, 2'd1, "R2 in-place update");

      // R4: fill up to capacity, nothing evicted while slots remain
      for (int i = 4; i < N; i++) do_fill(20'h01000 + VW'(i), 20'h20000 + PW'(i), 4'b0011, 0);
      sweep("R4 no early eviction");

      // R5 + R6: touch some entries, then evict the oldest
      do_lookup(20'h01010, 2'd1, "R6 touch");
      do_lookup(20'h01020, 2'd0, "R6 touch");
      do_lookup(20'h00103, 2'd1, "R6 faulting hit touches");
      for (int i = 0; i < 3; i++) do_fill(20'h05000 + VW'(i), 20'h30000 + PW'(i), 4'b0111, 0);
      sweep("R5 LRU victim");

      // R6: a miss does not change replacement order
      do_lookup(20'h0BEEF, 2'd0, "R6 miss no touch");
      do_fill(20'h06000, 20'h31111, 4'b0001, 0);
      sweep("R6 miss left order");

      // R6: lookup with lk_valid low does not touch the oldest entry
      k = oldest_slot();
      do_ghost(m_vpn[k]);
      do_fill(20'h06001, 20'h32222, 4'b0001, 0);
      sweep("R6 invalid lookup ignored");

      // R7: flush empties everything; flush beats a same-cycle fill
      do_flush();
      sweep("R7 flush");
      do_fill(20'h07000, 20'h33333, 4'b0111, 1);
      do_lookup(20'h07000, 2'd0, "R7 fill dropped by flush");
      do_fill(20'h07001, 20'h34444, 4'b0111, 0);
      do_fill(20'h07002, 20'h35555, 4'b0010, 0);
      do_lookup(20'h07001, 2'd2, "R8 refill after flush");
      do_lookup(20'h07002, 2'd0, "R3 write-only read faults");

      do_idle();
      do_idle();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule